// File: doc/BRIEF.md
# Write-Queue / Read-Latch Bus Buffer

This block sits between a fast master bus (side A) and a slower target bus (side B). It carries 18-bit words both ways. Writes from side A go into a four-entry first-in first-out queue. The master can post several writes back to back while side B drains them at its own pace. A full flag and an empty flag report how full the queue is. A clear input, sampled on the clock edge, empties the queue.

Reads run the other way through a level-sensitive latch. While the latch enable is high, side B data passes straight to side A. When the enable goes low, the value present at that moment is held on side A. Each direction has its own active-low output enable. A disabled output is driven to high impedance. The two paths are independent, so queued writes and direct reads can be in progress at the same time.

Top module: `rwbuf_top`

## Requirements
- R1: When `wq_push` is high and the queue is not full, `a_wdata` is stored on the rising clock edge. Words leave in the order they were stored.
- R2: `wq_full` is high exactly when the queue holds 4 words.
- R3: A push while the queue is full and no pop is requested is ignored. The occupancy and the queued words stay unchanged.
- R4: When `wq_pop` is high and the queue is not empty, the oldest word is removed on the rising clock edge. A pop while empty is ignored.
- R5: Push and pop in the same cycle on a queue that is neither empty nor full leave the occupancy unchanged. The same pair on an empty queue acts as a push only. On a full queue it acts as a pop only.
- R6: When `wq_clr` is high at a rising edge, the queue becomes empty with `wq_full` low, whatever the strobes are.
- R7: While the queue is not empty and `b_oe_n` is low, `b_wdata` shows the oldest queued word. While `b_oe_n` is high, `b_wdata` is high impedance.
- R8: While `rl_open` is high, `a_rdata` follows `b_rdata` combinationally.
- R9: After `rl_open` falls, `a_rdata` holds the `b_rdata` value present at the fall, for as long as `rl_open` stays low.
- R10: While `a_oe_n` is high, `a_rdata` is high impedance. When it returns low, the latched value reappears.
- R11: `wq_empty` is high exactly when the queue holds 0 words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the write queue |
| wq_clr | input | 1 | Clear of the queue, sampled on the rising edge, active high |
| wq_push | input | 1 | Side A write strobe |
| a_wdata | input | 18 | Side A write data |
| wq_pop | input | 1 | Side B read strobe for the queue |
| b_oe_n | input | 1 | Active-low output enable for side B |
| b_wdata | output | 18 | Oldest queued word, driven toward side B |
| wq_full | output | 1 | Queue holds four words |
| wq_empty | output | 1 | Queue holds no words |
| b_rdata | input | 18 | Side B read data |
| rl_open | input | 1 | Read latch enable: high is transparent, low holds |
| a_oe_n | input | 1 | Active-low output enable for side A |
| a_rdata | output | 18 | Latched read data, driven toward side A |

## Verification
The assertions check, on every clock cycle, the flag rules that hold at all times:
- a push into a full queue with no pop leaves it full;
- a pop from an empty queue with no push leaves it empty;
- a simultaneous push and pop in the middle range keeps the count;
- a clear always ends empty;
- the full and empty flags are never high together;
- the latch is transparent while its enable is high and holds while it is low.

Only the bench scenarios can show that words come out in order after the queue has wrapped, that a write rejected while full never shows up later, and that a disabled output comes back with the right value. The bench checks these against a behavioural queue model at every clock.

// File: rtl/rwbuf_pkg.sv
package rwbuf_pkg;
    localparam int unsigned WORD_W_DEF  = 18;
    localparam int unsigned SLOTS_DEF   = 4;

    typedef enum logic [1:0] {
        OCC_HOLD = 2'd0,
        OCC_INC  = 2'd1,
        OCC_DEC  = 2'd2
    } occ_op_t;

    function automatic occ_op_t occ_decide(input logic pushed, input logic popped);
        occ_decide = OCC_HOLD;
        if (pushed && !popped) occ_decide = OCC_INC;
        if (popped && !pushed) occ_decide = OCC_DEC;
    endfunction
endpackage

// File: rtl/rwbuf_wqueue.sv
module rwbuf_wqueue
    import rwbuf_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF,
    parameter int unsigned SLOTS  = SLOTS_DEF
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              push,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              full,
    output logic              empty
);
    localparam int unsigned PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int unsigned CNT_W = $clog2(SLOTS + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(SLOTS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(SLOTS);

    typedef struct packed {
        logic [SLOTS-1:0][WORD_W-1:0] mem;
        logic [PTR_W-1:0]             wp;
        logic [PTR_W-1:0]             rp;
        logic [CNT_W-1:0]             cnt;
    } wq_state_t;

    wq_state_t s_q;
    wq_state_t s_d;
    logic      take_d;
    logic      give_d;
    occ_op_t   op_d;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        ptr_next = (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d    = s_q;
        take_d = push && (s_q.cnt != CNT_MAX);
        give_d = pop && (s_q.cnt != '0);
        op_d   = occ_decide(take_d, give_d);
        if (take_d) begin
            s_d.mem[s_q.wp] = wdata;
            s_d.wp          = ptr_next(s_q.wp);
        end
        if (give_d) begin
            s_d.rp = ptr_next(s_q.rp);
        end
        unique case (op_d)
            OCC_INC: s_d.cnt = s_q.cnt + 1'b1;
            OCC_DEC: s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
        if (clr) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign head  = s_q.mem[s_q.rp];
    assign full  = (s_q.cnt == CNT_MAX);
    assign empty = (s_q.cnt == '0);

    // R3: a rejected push on a full queue keeps it full
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (clr)
        (full && push && !pop) |=> full);

    // R4: a pop on an empty queue keeps it empty
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (clr)
        (empty && pop && !push) |=> empty);

    // R5: paired push and pop in the middle range keep the count
    a_r5_count_kept: assert property (@(posedge clk) disable iff (clr)
        (!empty && !full && push && pop) |=> $stable(s_q.cnt));

    // R6: clear always leaves an empty, non-full queue
    a_r6_clear_empties: assert property (@(posedge clk)
        clr |=> (empty && !full));

    // R2 / R11: flags are exclusive
    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (clr)
        !(full && empty));
endmodule

// File: rtl/rwbuf_rdlatch.sv
module rwbuf_rdlatch
    import rwbuf_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic              open,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    logic [WORD_W-1:0] hold_q;

    always_latch begin
        if (open) hold_q <= din;
    end

    assign dout = hold_q;
endmodule

// File: rtl/rwbuf_outdrv.sv
module rwbuf_outdrv
    import rwbuf_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic              oe_n,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] pad
);
    assign pad = oe_n ? {WORD_W{1'bz}} : din;
endmodule

// File: rtl/rwbuf_top.sv
module rwbuf_top
    import rwbuf_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF,
    parameter int unsigned SLOTS  = SLOTS_DEF
) (
    input  logic              clk,
    input  logic              wq_clr,
    input  logic              wq_push,
    input  logic [WORD_W-1:0] a_wdata,
    input  logic              wq_pop,
    input  logic              b_oe_n,
    output logic [WORD_W-1:0] b_wdata,
    output logic              wq_full,
    output logic              wq_empty,
    input  logic [WORD_W-1:0] b_rdata,
    input  logic              rl_open,
    input  logic              a_oe_n,
    output logic [WORD_W-1:0] a_rdata
);
    logic [WORD_W-1:0] head_w;
    logic [WORD_W-1:0] latched_w;

    rwbuf_wqueue #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_wq (
        .clk   (clk),
        .clr   (wq_clr),
        .push  (wq_push),
        .wdata (a_wdata),
        .pop   (wq_pop),
        .head  (head_w),
        .full  (wq_full),
        .empty (wq_empty)
    );

    rwbuf_rdlatch #(.WORD_W(WORD_W)) u_rl (
        .open (rl_open),
        .din  (b_rdata),
        .dout (latched_w)
    );

    rwbuf_outdrv #(.WORD_W(WORD_W)) u_bdrv (
        .oe_n (b_oe_n),
        .din  (head_w),
        .pad  (b_wdata)
    );

    rwbuf_outdrv #(.WORD_W(WORD_W)) u_adrv (
        .oe_n (a_oe_n),
        .din  (latched_w),
        .pad  (a_rdata)
    );

    // R8: open latch passes side B data
    a_r8_transparent: assert property (@(posedge clk) disable iff (wq_clr)
        rl_open |-> (latched_w == b_rdata));

    // R9: closed latch keeps its value
    a_r9_hold: assert property (@(posedge clk) disable iff (wq_clr)
        (!rl_open && $past(!rl_open)) |-> $stable(latched_w));
endmodule

// File: tb/rwbuf_top_test.sv
`timescale 1ns/1ps
module rwbuf_top_test;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         wq_clr = 1'b1;
    logic         wq_push = 1'b0;
    logic [W-1:0] a_wdata = '0;
    logic         wq_pop = 1'b0;
    logic         b_oe_n = 1'b0;
    logic [W-1:0] b_wdata;
    logic         wq_full;
    logic         wq_empty;
    logic [W-1:0] b_rdata = '0;
    logic         rl_open = 1'b1;
    logic         a_oe_n = 1'b0;
    logic [W-1:0] a_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [W-1:0] model[$];

    always #4 clk = ~clk;

    rwbuf_top uut (
        .clk(clk), .wq_clr(wq_clr), .wq_push(wq_push), .a_wdata(a_wdata),
        .wq_pop(wq_pop), .b_oe_n(b_oe_n), .b_wdata(b_wdata), .wq_full(wq_full),
        .wq_empty(wq_empty), .b_rdata(b_rdata), .rl_open(rl_open),
        .a_oe_n(a_oe_n), .a_rdata(a_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(wq_full === (model.size() == 4), "R2 full", W'(wq_full), W'(model.size() == 4));
        check(wq_empty === (model.size() == 0), "R11 empty", W'(wq_empty), W'(model.size() == 0));
        if (model.size() > 0 && !b_oe_n)
            check(b_wdata === model[0], "R1/R7 head", b_wdata, model[0]);
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input bit clr, input bit wr, input logic [W-1:0] d, input bit rd);
        wq_clr = clr; wq_push = wr; a_wdata = d; wq_pop = rd;
        @(posedge clk);
        if (clr) model.delete();
        else begin
            bit do_pop;
            bit do_push;
            do_pop  = rd && model.size() > 0;
            do_push = wr && model.size() < 4;
            if (do_pop) void'(model.pop_front());
            if (do_push) model.push_back(d);
        end
        @(negedge clk);
        wq_clr = 0; wq_push = 0; wq_pop = 0;
        compare_all();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(1, 0, '0, 0);
        step(1, 0, '0, 0);
        // reset state (R6, R11)
        check(wq_empty === 1'b1 && wq_full === 1'b0, "R6 reset state", {wq_full, wq_empty}, 18'h1);

        // R1 R2: fill to four
        for (int i = 0; i < 4; i++) step(0, 1, 18'h10A00 + W'(i), 0);
        check(wq_full === 1'b1, "R2 full at four", W'(wq_full), 18'h1);
        // R3: push while full ignored
        step(0, 1, 18'h3DEAD, 0);
        step(0, 1, 18'h3BEEF, 0);
        // R5: push+pop when full acts as pop only
        step(0, 1, 18'h2FACE, 1);
        // R4: drain with wrap, then pop while empty
        for (int i = 0; i < 4; i++) step(0, 0, '0, 1);
        step(0, 0, '0, 1);
        check(wq_empty === 1'b1, "R4 empty after underflow try", W'(wq_empty), 18'h1);
        // R5: push+pop on empty acts as push only
        step(0, 1, 18'h01234, 1);
        check(model.size() == 1 && b_wdata === 18'h01234, "R5 empty pair", b_wdata, 18'h01234);
        step(0, 1, 18'h05555, 0);
        // R5: mid-range pairs keep count
        for (int i = 0; i < 6; i++) step(0, 1, 18'h20000 + W'(i * 7), 1);
        check(wq_full === 0 && wq_empty === 0, "R5 mid occupancy", {wq_full, wq_empty}, '0);
        // R7: disable side B output
        b_oe_n = 1;
        #1;
        check(b_wdata !== model[0], "R7 disabled output", b_wdata, model[0]);
        b_oe_n = 0;
        #1;
        check(b_wdata === model[0], "R7 re-enabled output", b_wdata, model[0]);
        // R6: clear wins over strobes
        step(0, 1, 18'h0AAAA, 0);
        step(1, 1, 18'h0BBBB, 1);
        check(wq_empty === 1'b1, "R6 clear with strobes", W'(wq_empty), 18'h1);
        // mixed pattern
        for (int i = 0; i < 20; i++) step(0, (i % 3) != 2, 18'h15000 + W'(i), (i % 4) == 3);

        // R8: transparent
        @(negedge clk); rl_open = 1; b_rdata = 18'h1F0F0;
        #1 check(a_rdata === 18'h1F0F0, "R8 transparent", a_rdata, 18'h1F0F0);
        b_rdata = 18'h00F0F;
        #1 check(a_rdata === 18'h00F0F, "R8 follows", a_rdata, 18'h00F0F);
        // R9: hold after fall
        @(negedge clk); rl_open = 0;
        #1 b_rdata = 18'h2AAAA;
        #1 check(a_rdata === 18'h00F0F, "R9 hold", a_rdata, 18'h00F0F);
        @(negedge clk); b_rdata = 18'h15555;
        #1 check(a_rdata === 18'h00F0F, "R9 hold later", a_rdata, 18'h00F0F);
        // R10: disable and re-enable side A
        a_oe_n = 1;
        #1 check(a_rdata !== 18'h00F0F, "R10 disabled", a_rdata, 18'h00F0F);
        a_oe_n = 0;
        #1 check(a_rdata === 18'h00F0F, "R10 re-enabled", a_rdata, 18'h00F0F);
        @(negedge clk); rl_open = 1;
        #1 check(a_rdata === 18'h15555, "R8 reopen", a_rdata, 18'h15555);
        @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule